// File: doc/BRIEF.md
# Dual-Direction Bus Transceiver Register

This block moves an 18-bit word between two buses, called side A and side B, one path for each direction. Each path has its own storage register and a mode chosen by a latch-enable input and a path clock input. With the latch enable high, the path passes data straight through. With the latch enable low, the path holds its stored word, and it takes a new word on each high-to-low transition of its path clock. Each path also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low.

Tri-state pads are not used. Each side is modelled as an input bus, an output bus and a drive flag, and the surrounding logic resolves the shared wire. The path clocks are ordinary data inputs, sampled by the system clock `clk`. A falling edge on a path clock is recognised when the path clock was high at one `clk` rising edge and is low at the next one. All registers reset asynchronously to zero.

Top module: `xcvr_dual_reg`

## Requirements
- R1: While `rst_n` is low, and after reset until the first capture, both storage registers read zero. A path whose latch enable is low therefore drives zero on its output bus.
- R2: When a path's latch enable is high, its output bus equals its input bus in the same cycle. At every `clk` rising edge, the storage register also takes the input word.
- R3: When a path's latch enable is low and its path clock shows no high-to-low transition between two `clk` edges, the output keeps the stored word, whatever the input does.
- R4: When the latch enable is low, a path clock sampled high at one `clk` edge and low at the next stores the input word present at that second edge. The output shows the new word from then on.
- R5: `bOe` is 1 exactly when `abOe` is 1. The A-to-B enable is active high.
- R6: The B-to-A path behaves like the A-to-B path, using `baLatchEn` and `baClk`. Its enable is active low: `aOe` is 1 exactly when `baOeN` is 0.
- R7: An output enable changes only the drive flag. A path stores a word on a falling path-clock edge while its output is disabled, and shows that word once the output is enabled again.
- R8: A rising path-clock edge never stores a word. While the latch enable is high, a falling path-clock edge has no effect beyond the transparent value.
- R9: When the latch enable goes low, the path holds the word taken at the last `clk` edge at which the latch enable was high. This applies both when the path clock is already low and when it is high at that moment.
- R10: Activity on one path leaves the other path's output bus and drive flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every control input |
| rst_n | input | 1 | Asynchronous reset, active low |
| aIn | input | 18 | Word received from side A |
| aOut | output | 18 | Word the B-to-A path presents to side A |
| aOe | output | 1 | Drive flag for side A |
| bIn | input | 18 | Word received from side B |
| bOut | output | 18 | Word the A-to-B path presents to side B |
| bOe | output | 1 | Drive flag for side B |
| abOe | input | 1 | A-to-B output enable, active high |
| abLatchEn | input | 1 | A-to-B latch enable; high selects transparent mode |
| abClk | input | 1 | A-to-B path clock; a falling edge stores a word |
| baOeN | input | 1 | B-to-A output enable, active low |
| baLatchEn | input | 1 | B-to-A latch enable; high selects transparent mode |
| baClk | input | 1 | B-to-A path clock; a falling edge stores a word |

## Verification
The hardest case to reach is the hold after the latch enable falls while the path clock is already low (R9). The stimulus has to drop the path clock during transparent mode, where R8 says the edge has no effect of its own. It then lowers the latch enable and changes the input in that same cycle. Only then does the output show the last transparent word instead of the new input. The bench builds that sequence explicitly. It also covers the case where the clock is held high when the latch enable falls. In a further case, a word is stored while the output is disabled, and the enable is raised afterwards so the stored word shows up at the port.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  localparam int DATA_W  = 18;
  localparam int NUM_DIR = 2;

  typedef struct packed {
    logic passThru;
    logic capture;
    logic drive;
  } xcvr_strobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
`timescale 1ns/1ps
module xcvr_ctrl #(
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  latchEn,
  input  logic                  pathClk,
  input  logic                  oeIn,
  output xcvr_pkg::xcvr_strobe_t strobe
);
  logic prevClk;
  logic fallSeen;
  logic driveOn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevClk <= 1'b0;
    else        prevClk <= pathClk;
  end

  assign fallSeen = prevClk & ~pathClk;

  generate
    if (OE_ACTIVE_LOW) begin : g_oeLow
      assign driveOn = ~oeIn;
    end else begin : g_oeHigh
      assign driveOn = oeIn;
    end
  endgenerate

  always_comb begin
    strobe.passThru = latchEn;
    strobe.capture  = ~latchEn & fallSeen;
    strobe.drive    = driveOn;
  end

  AST_CAPTURE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |-> ($past(pathClk) && !pathClk)); // R4

endmodule

// File: rtl/xcvr_path.sv
`timescale 1ns/1ps
module xcvr_path #(
  parameter int WIDTH = xcvr_pkg::DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  xcvr_pkg::xcvr_strobe_t strobe,
  input  logic [WIDTH-1:0]      dIn,
  output logic [WIDTH-1:0]      dOut,
  output logic                  oeOut
);
  logic [WIDTH-1:0] store;
  logic             loadNow;

  assign loadNow = strobe.passThru | strobe.capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       store <= '0;
    else if (loadNow) store <= dIn;
  end

  assign dOut  = strobe.passThru ? dIn : store;
  assign oeOut = strobe.drive;

  AST_TRACK_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.passThru |=> (store == $past(dIn))); // R2

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.passThru && !strobe.capture) |=> $stable(store)); // R3

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> (store == $past(dIn))); // R4

  AST_DRIVE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.passThru && !strobe.capture && $rose(strobe.drive)) |=> $stable(store)); // R7

endmodule

// File: rtl/xcvr_dual_reg.sv
`timescale 1ns/1ps
module xcvr_dual_reg #(
  parameter int WIDTH = xcvr_pkg::DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe,
  input  logic             abOe,
  input  logic             abLatchEn,
  input  logic             abClk,
  input  logic             baOeN,
  input  logic             baLatchEn,
  input  logic             baClk
);
  import xcvr_pkg::*;

  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;

  logic [WIDTH-1:0] srcWord [NUM_DIR];
  logic [WIDTH-1:0] dstWord [NUM_DIR];
  logic             leSel   [NUM_DIR];
  logic             pcSel   [NUM_DIR];
  logic             oeSel   [NUM_DIR];
  logic             drvFlag [NUM_DIR];
  xcvr_strobe_t     strobes [NUM_DIR];

  assign srcWord[DIR_AB] = aIn;
  assign srcWord[DIR_BA] = bIn;
  assign leSel[DIR_AB]   = abLatchEn;
  assign leSel[DIR_BA]   = baLatchEn;
  assign pcSel[DIR_AB]   = abClk;
  assign pcSel[DIR_BA]   = baClk;
  assign oeSel[DIR_AB]   = abOe;
  assign oeSel[DIR_BA]   = baOeN;

  generate
    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
      xcvr_ctrl #(
        .OE_ACTIVE_LOW(g == DIR_BA)
      ) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .latchEn(leSel[g]),
        .pathClk(pcSel[g]),
        .oeIn   (oeSel[g]),
        .strobe (strobes[g])
      );

      xcvr_path #(
        .WIDTH(WIDTH)
      ) i_path (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(strobes[g]),
        .dIn   (srcWord[g]),
        .dOut  (dstWord[g]),
        .oeOut (drvFlag[g])
      );
    end
  endgenerate

  assign bOut = dstWord[DIR_AB];
  assign bOe  = drvFlag[DIR_AB];
  assign aOut = dstWord[DIR_BA];
  assign aOe  = drvFlag[DIR_BA];

endmodule

// File: tb/test_xcvr_dual_reg.sv
`timescale 1ns/1ps
module test_xcvr_dual_reg;
  localparam int PERIOD = 10;
  localparam int W = 18;

  typedef struct {
    logic [W-1:0] bOutExp;
    logic [W-1:0] aOutExp;
    logic         bOeExp;
    logic         aOeExp;
    string        tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] aIn, bIn, aOut, bOut;
  logic aOe, bOe, abOe, abLatchEn, abClk, baOeN, baLatchEn, baClk;

  int checks = 0;
  int fails = 0;
  int clashCycles = 0;
  bit finished = 1'b0;
  expItem_t scoreQ[$];

  logic [W-1:0] mStoreAb, mStoreBa;
  logic mPrevAb, mPrevBa;

  always #(PERIOD/2) clk = ~clk;

  xcvr_dual_reg i_xcvr_dual_reg (
    .clk(clk), .rst_n(rst_n),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .abOe(abOe), .abLatchEn(abLatchEn), .abClk(abClk),
    .baOeN(baOeN), .baLatchEn(baLatchEn), .baClk(baClk)
  );

  task automatic step(input logic [W-1:0] av, input logic abo, input logic abl,
                      input logic abc, input logic [W-1:0] bv, input logic bao,
                      input logic bal, input logic bac, input string tag);
    expItem_t it;
    @(negedge clk);
    aIn = av; abOe = abo; abLatchEn = abl; abClk = abc;
    bIn = bv; baOeN = bao; baLatchEn = bal; baClk = bac;
    @(posedge clk);
    if (abl || (mPrevAb && !abc)) mStoreAb = av;
    mPrevAb = abc;
    if (bal || (mPrevBa && !bac)) mStoreBa = bv;
    mPrevBa = bac;
    it.bOutExp = abl ? av : mStoreAb;
    it.aOutExp = bal ? bv : mStoreBa;
    it.bOeExp  = abo;
    it.aOeExp  = ~bao;
    it.tag     = tag;
    scoreQ.push_back(it);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Monitor: pops expected items a quarter period after each rising edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (aOe && bOe) clashCycles++;
      if (scoreQ.size() > 0) begin
        it = scoreQ.pop_front();
        checks++;
        if (bOut !== it.bOutExp || aOut !== it.aOutExp ||
            bOe !== it.bOeExp || aOe !== it.aOeExp) begin
          fails++;
          $display("FAIL %s: bOut=%h/%h aOut=%h/%h bOe=%b/%b aOe=%b/%b (actual/expected)",
                   it.tag, bOut, it.bOutExp, aOut, it.aOutExp, bOe, it.bOeExp, aOe, it.aOeExp);
        end
      end
    end
  end

  initial begin
    #(PERIOD*5000);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    mStoreAb = '0; mStoreBa = '0; mPrevAb = 1'b0; mPrevBa = 1'b0;
    rst_n = 1'b0;
    aIn = 18'h3C3C3; bIn = 18'h15A5A; abOe = 1'b1; abLatchEn = 1'b0; abClk = 1'b0;
    baOeN = 1'b0; baLatchEn = 1'b0; baClk = 1'b0;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    checks++;
    if (aOut !== '0 || bOut !== '0) begin
      fails++;
      $display("FAIL R1 reset: aOut=%h bOut=%h expected 0/0", aOut, bOut);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: after reset, latch enable low, clocks low -> zeros
    step(18'h2AAAA, 1, 0, 0, 18'h15555, 0, 0, 0, "R1 post-reset");
    // R2 transparent A-to-B
    step(18'h12345, 1, 1, 0, 18'h15555, 0, 0, 0, "R2 transparent");
    step(18'h3ABCD, 1, 1, 1, 18'h15555, 0, 0, 0, "R2 transparent clk high");
    // R9 latch enable falls with clock high
    step(18'h00111, 1, 0, 1, 18'h15555, 0, 0, 0, "R9 fall with clk high");
    step(18'h22222, 1, 0, 1, 18'h15555, 0, 0, 0, "R3 hold clk high");
    // R4 falling edge capture
    step(18'h05555, 1, 0, 0, 18'h15555, 0, 0, 0, "R4 capture on fall");
    step(18'h0AAAA, 1, 0, 0, 18'h15555, 0, 0, 0, "R3 hold clk low");
    // R8 rising edge does not capture
    step(18'h1F0F0, 1, 0, 1, 18'h15555, 0, 0, 0, "R8 rise no capture");
    // R8 falling edge while transparent
    step(18'h00777, 1, 1, 1, 18'h15555, 0, 0, 0, "R8 transparent");
    step(18'h00888, 1, 1, 0, 18'h15555, 0, 0, 0, "R8 fall while transparent");
    // R9 latch enable falls with clock already low
    step(18'h3FFFF, 1, 0, 0, 18'h15555, 0, 0, 0, "R9 fall with clk low");
    step(18'h01010, 1, 0, 0, 18'h15555, 0, 0, 0, "R9 still holding");
    // R5/R7 capture while output disabled
    step(18'h12121, 0, 0, 1, 18'h15555, 0, 0, 0, "R5 disabled");
    step(18'h34343, 0, 0, 0, 18'h15555, 0, 0, 0, "R7 capture while disabled");
    step(18'h00000, 1, 0, 0, 18'h15555, 0, 0, 0, "R7 word visible on enable");
    // B-to-A path, A path parked
    step(18'h00000, 1, 0, 0, 18'h2AAAA, 0, 1, 0, "R6 transparent B-to-A");
    step(18'h00000, 1, 0, 0, 18'h11111, 0, 0, 1, "R6 hold B-to-A");
    step(18'h00000, 1, 0, 0, 18'h0F00F, 0, 0, 0, "R6 capture B-to-A");
    step(18'h00000, 1, 0, 0, 18'h33333, 1, 0, 0, "R6 enable active low off");
    step(18'h00000, 1, 0, 0, 18'h33333, 0, 0, 0, "R6 enable active low on");
    // R10 independence: A path activity, B-to-A output unchanged
    step(18'h2BEEF, 1, 1, 0, 18'h01234, 0, 0, 0, "R10 A active, B-to-A steady");
    step(18'h2BEEF, 1, 0, 0, 18'h3CAFE, 0, 1, 1, "R10 B active, A-to-B steady");
    step(18'h00001, 0, 0, 0, 18'h3CAFE, 1, 1, 0, "R10 both disabled");

    repeat (3) @(posedge clk);
    #(PERIOD/4);
    if (clashCycles > 0)
      $display("note: %0d cycles with both sides driving", clashCycles);
    finish_run();
  end
endmodule